// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, on every clock, which of four hardware threads of a simultaneous multithreading core may use the instruction fetch unit in that cycle. It also tells the fetch unit how many of the eight fetch slots each chosen thread may fill.

The ranking rule is picked at runtime from four options: plain rotation, fewest unresolved branches, fewest outstanding data cache misses, or fewest front-end instructions. Front-end instructions are those held in decode, rename and the issue queues. The block keeps its own per-thread occupancy counters, and single-cycle event pulses from the pipeline move them up and down. A thread that is waiting on an instruction cache miss cannot be chosen.

A second control input selects one or two winners per cycle. A third control input decides how two winners share the budget. In one scheme the second winner fills only the slots the first leaves unused. In the other, each winner gets half of the slots, and a lone winner may take the full eight.

Top module: `smt_fetch_arbiter`

## Requirements
- R1: A thread whose bit in `icmiss_i` is high is never reported as a valid winner in that cycle. Two valid winners are always different threads.
- R2: The policy code on `policy_i` is 0 for rotation. In rotation, eligible threads are taken in rising ID order, wrapping after thread 3. Immediately after reset, thread 0 comes first.
- R3: Policy code 3 ranks by front-end count. A thread's count goes up by one for each `fe_enter_i` pulse and down by one for each `fe_leave_i` pulse. The thread with the smallest count wins.
- R4: Policy code 1 ranks by the unresolved-branch count. The count goes up on `br_enter_i` and down on `br_resolve_i`.
- R5: Policy code 2 ranks by the outstanding data-miss count. The count goes up on `dm_start_i` and down on `dm_end_i`.
- R6: Equal counts are resolved by a rotating pointer, which reset sets to thread 0. The pointer prefers that thread first, then the next higher IDs, wrapping around. After any cycle with a valid first winner, the pointer moves to the thread just after that winner.
- R7: Each counter is 7 bits wide and stays within 0 to 127. An increment at 127 and a decrement at 0 have no effect. An increment and a decrement in the same cycle leave the count unchanged. Counter changes take effect in the ranking on the next cycle.
- R8: When `dual_i` is 0, only the first winner is valid. It receives its demand limited to 8, and `win1_slots_o` is 0. A demand is a 4-bit field per thread, at bits [4t+3:4t] of `demand_i`; any value above 8 counts as 8.
- R9: When `dual_i` is 1 and `halves_i` is 0, the first winner receives its demand limited to 8. The second winner receives the lesser of its own demand and the slots left over from 8.
- R10: When `dual_i` is 1 and `halves_i` is 1, each of two valid winners receives at most 4 slots. If only one thread is eligible, that thread receives its demand limited to 8.
- R11: The two slot grants never add up to more than 8. A grant to an invalid winner is 0.
- R12: When every thread has an instruction cache miss, both valid outputs are low and the rotating pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 2 | Ranking policy: 0 rotate, 1 branches, 2 data misses, 3 front-end count |
| dual_i | input | 1 | 1 selects two winners per cycle |
| halves_i | input | 1 | With two winners: 1 gives each winner half of the slots, 0 lets the second winner fill what the first leaves |
| icmiss_i | input | 4 | Per-thread instruction cache miss in progress |
| fe_enter_i | input | 4 | Per-thread pulse: instruction entered decode |
| fe_leave_i | input | 4 | Per-thread pulse: instruction left the issue queue |
| br_enter_i | input | 4 | Per-thread pulse: branch entered the front end |
| br_resolve_i | input | 4 | Per-thread pulse: branch resolved |
| dm_start_i | input | 4 | Per-thread pulse: data cache miss started |
| dm_end_i | input | 4 | Per-thread pulse: data cache miss completed |
| demand_i | input | 16 | Per-thread requested fetch slots, 4 bits each |
| win0_id_o | output | 2 | First winner thread ID |
| win0_vld_o | output | 1 | First winner valid |
| win1_id_o | output | 2 | Second winner thread ID |
| win1_vld_o | output | 1 | Second winner valid |
| win0_slots_o | output | 4 | Slots granted to the first winner |
| win1_slots_o | output | 4 | Slots granted to the second winner |

## Verification
Counter saturation is the hardest case to reach from the ports, because the counts are never visible directly. The stimulus first drives 130 increment pulses into one thread and then 127 decrements. Only a counter that stopped at 127 ends at zero, and the ranking then reveals this against rivals that each hold one. The lower bound and the same-cycle increment-plus-decrement case are exposed the same way, by ranking against known rival counts. The pointer hold during an all-miss stall is checked by the rotation order once the misses clear.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    localparam int NT      = 4;
    localparam int TID_W   = $clog2(NT);
    localparam int CNT_W   = 7;
    localparam int FETCH_W = 8;
    localparam int HALF_W  = FETCH_W / 2;
    localparam int SLOT_W  = $clog2(FETCH_W + 1);

    typedef enum logic [1:0] {
        POL_ROTATE = 2'd0,
        POL_BRANCH = 2'd1,
        POL_DMISS  = 2'd2,
        POL_FRONT  = 2'd3
    } policy_e;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic             vld;
        logic [TID_W-1:0] id;
    } pick_t;

    function automatic cnt_t sat_step(cnt_t c, logic inc, logic dec);
        cnt_t r = c;
        if (inc && !dec && c != {CNT_W{1'b1}}) r = c + 1'b1;
        if (dec && !inc && c != '0)            r = c - 1'b1;
        return r;
    endfunction

    function automatic slot_t umin(slot_t a, slot_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/fsel_occupancy.sv
module fsel_occupancy
    import fsel_pkg::*;
#(
    parameter int N = NT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          inc_i,
    input  logic [N-1:0]          dec_i,
    output logic [N-1:0][CNT_W-1:0] cnt_o
);
    for (genvar t = 0; t < N; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst) cnt_o[t] <= '0;
            else     cnt_o[t] <= sat_step(cnt_o[t], inc_i[t], dec_i[t]);
        end
    end
endmodule

// File: rtl/fsel_ranker.sv
module fsel_ranker
    import fsel_pkg::*;
#(
    parameter int N = NT
) (
    input  logic [N-1:0][CNT_W-1:0] key_i,
    input  logic [N-1:0]            elig_i,
    input  logic [TID_W-1:0]        ptr_i,
    input  logic                    dual_i,
    output pick_t                   p0_o,
    output pick_t                   p1_o
);
    cnt_t best0, best1;

    always_comb begin
        p0_o  = '0;
        p1_o  = '0;
        best0 = '0;
        best1 = '0;
        // scan from the pointer so the first strict minimum found wins ties
        for (int k = 0; k < N; k++) begin
            logic [TID_W-1:0] idx;
            idx = TID_W'((int'(ptr_i) + k) % N);
            if (elig_i[idx] && (!p0_o.vld || key_i[idx] < best0)) begin
                p0_o.vld = 1'b1;
                p0_o.id  = idx;
                best0    = key_i[idx];
            end
        end
        for (int k = 0; k < N; k++) begin
            logic [TID_W-1:0] idx;
            idx = TID_W'((int'(ptr_i) + k) % N);
            if (dual_i && elig_i[idx] && !(p0_o.vld && idx == p0_o.id)
                && (!p1_o.vld || key_i[idx] < best1)) begin
                p1_o.vld = 1'b1;
                p1_o.id  = idx;
                best1    = key_i[idx];
            end
        end
    end
endmodule

// File: rtl/fsel_budget.sv
module fsel_budget
    import fsel_pkg::*;
(
    input  pick_t p0_i,
    input  pick_t p1_i,
    input  logic  dual_i,
    input  logic  halves_i,
    input  slot_t dem0_i,
    input  slot_t dem1_i,
    output slot_t s0_o,
    output slot_t s1_o
);
    localparam slot_t FULL = SLOT_W'(FETCH_W);
    localparam slot_t HALF = SLOT_W'(HALF_W);

    slot_t d0, d1;
    assign d0 = umin(dem0_i, FULL);
    assign d1 = umin(dem1_i, FULL);

    always_comb begin
        s0_o = '0;
        s1_o = '0;
        if (p0_i.vld) begin
            if (!dual_i) begin
                s0_o = d0;
            end else if (halves_i) begin
                if (p1_i.vld) begin
                    s0_o = umin(d0, HALF);
                    s1_o = umin(d1, HALF);
                end else begin
                    s0_o = d0;
                end
            end else begin
                s0_o = d0;
                if (p1_i.vld) s1_o = umin(d1, FULL - d0);
            end
        end
    end
endmodule

// File: rtl/smt_fetch_arbiter.sv
module smt_fetch_arbiter
    import fsel_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            policy_i,
    input  logic                  dual_i,
    input  logic                  halves_i,
    input  logic [NT-1:0]         icmiss_i,
    input  logic [NT-1:0]         fe_enter_i,
    input  logic [NT-1:0]         fe_leave_i,
    input  logic [NT-1:0]         br_enter_i,
    input  logic [NT-1:0]         br_resolve_i,
    input  logic [NT-1:0]         dm_start_i,
    input  logic [NT-1:0]         dm_end_i,
    input  logic [NT*SLOT_W-1:0]  demand_i,
    output logic [TID_W-1:0]      win0_id_o,
    output logic                  win0_vld_o,
    output logic [TID_W-1:0]      win1_id_o,
    output logic                  win1_vld_o,
    output logic [SLOT_W-1:0]     win0_slots_o,
    output logic [SLOT_W-1:0]     win1_slots_o
);
    logic [NT-1:0][CNT_W-1:0] fe_cnt, br_cnt, dm_cnt, key;
    logic [TID_W-1:0]         ptr_q;
    pick_t                    p0, p1;
    policy_e                  pol;

    assign pol = policy_e'(policy_i);

    fsel_occupancy #(.N(NT)) u_fe (.clk(clk), .rst(rst), .inc_i(fe_enter_i), .dec_i(fe_leave_i),   .cnt_o(fe_cnt));
    fsel_occupancy #(.N(NT)) u_br (.clk(clk), .rst(rst), .inc_i(br_enter_i), .dec_i(br_resolve_i), .cnt_o(br_cnt));
    fsel_occupancy #(.N(NT)) u_dm (.clk(clk), .rst(rst), .inc_i(dm_start_i), .dec_i(dm_end_i),     .cnt_o(dm_cnt));

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            unique case (pol)
                POL_BRANCH: key[t] = br_cnt[t];
                POL_DMISS:  key[t] = dm_cnt[t];
                POL_FRONT:  key[t] = fe_cnt[t];
                default:    key[t] = '0;
            endcase
        end
    end

    fsel_ranker #(.N(NT)) u_rank (
        .key_i(key), .elig_i(~icmiss_i), .ptr_i(ptr_q), .dual_i(dual_i),
        .p0_o(p0), .p1_o(p1)
    );

    fsel_budget u_bud (
        .p0_i(p0), .p1_i(p1), .dual_i(dual_i), .halves_i(halves_i),
        .dem0_i(demand_i[p0.id*SLOT_W +: SLOT_W]),
        .dem1_i(demand_i[p1.id*SLOT_W +: SLOT_W]),
        .s0_o(win0_slots_o), .s1_o(win1_slots_o)
    );

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (p0.vld) ptr_q <= p0.id + 1'b1;
    end

    assign win0_id_o  = p0.id;
    assign win0_vld_o = p0.vld;
    assign win1_id_o  = p1.id;
    assign win1_vld_o = p1.vld;
endmodule

// File: rtl/fsel_chk.sv
module fsel_chk
    import fsel_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [1:0]         policy_i,
    input logic               dual_i,
    input logic               halves_i,
    input logic [NT-1:0]      icmiss_i,
    input logic [TID_W-1:0]   win0_id_o,
    input logic               win0_vld_o,
    input logic [TID_W-1:0]   win1_id_o,
    input logic               win1_vld_o,
    input logic [SLOT_W-1:0]  win0_slots_o,
    input logic [SLOT_W-1:0]  win1_slots_o
);
    // R1
    excl_win0_chk: assert property (@(posedge clk) disable iff (rst)
        win0_vld_o |-> !icmiss_i[win0_id_o]);
    // R1
    excl_win1_chk: assert property (@(posedge clk) disable iff (rst)
        win1_vld_o |-> (!icmiss_i[win1_id_o] && win0_vld_o && win1_id_o != win0_id_o));
    // R2
    rotate_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(win0_vld_o) && $past(policy_i) == 2'd0
         && policy_i == 2'd0 && icmiss_i == '0)
        |-> win0_id_o == TID_W'($past(win0_id_o) + 1'b1));
    // R8
    single_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !dual_i |-> (!win1_vld_o && win1_slots_o == '0));
    // R10
    halves_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (dual_i && halves_i && win1_vld_o) |-> (win0_slots_o <= SLOT_W'(HALF_W) && win1_slots_o <= SLOT_W'(HALF_W)));
    // R11
    budget_cap_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, win0_slots_o} + {1'b0, win1_slots_o}) <= (SLOT_W+1)'(FETCH_W));
    // R11
    idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !win0_vld_o |-> (win0_slots_o == '0 && win1_slots_o == '0));
    // R12
    none_elig_chk: assert property (@(posedge clk) disable iff (rst)
        (&icmiss_i) |-> (!win0_vld_o && !win1_vld_o));
endmodule

bind smt_fetch_arbiter fsel_chk u_chk (
    .clk(clk), .rst(rst), .policy_i(policy_i), .dual_i(dual_i), .halves_i(halves_i),
    .icmiss_i(icmiss_i), .win0_id_o(win0_id_o), .win0_vld_o(win0_vld_o),
    .win1_id_o(win1_id_o), .win1_vld_o(win1_vld_o),
    .win0_slots_o(win0_slots_o), .win1_slots_o(win1_slots_o)
);

// File: tb/sim_smt_fetch_arbiter.sv
`timescale 1ns/1ps
module sim_smt_fetch_arbiter;
    import fsel_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic [1:0]  policy_i = 2'd0;
    logic        dual_i = 1'b0, halves_i = 1'b0;
    logic [3:0]  icmiss_i = '0;
    logic [3:0]  fe_enter_i = '0, fe_leave_i = '0, br_enter_i = '0;
    logic [3:0]  br_resolve_i = '0, dm_start_i = '0, dm_end_i = '0;
    logic [15:0] demand_i;
    logic [1:0]  win0_id_o, win1_id_o;
    logic        win0_vld_o, win1_vld_o;
    logic [3:0]  win0_slots_o, win1_slots_o;

    int dem [4] = '{8, 8, 8, 8};
    always_comb for (int t = 0; t < 4; t++) demand_i[4*t +: 4] = 4'(dem[t]);

    smt_fetch_arbiter u0 (.*);

    int n_chk = 0, n_bad = 0;
    int m_fe [4], m_br [4], m_dm [4];
    int m_ptr = 0;

    function automatic int sat(int c, logic inc, logic dec);
        if (inc && !dec && c < 127) return c + 1;
        if (dec && !inc && c > 0)   return c - 1;
        return c;
    endfunction

    function automatic int keyof(int t);
        case (policy_i)
            2'd1: return m_br[t];
            2'd2: return m_dm[t];
            2'd3: return m_fe[t];
            default: return 0;
        endcase
    endfunction

    task automatic model(output int e0, output bit v0, output int e1, output bit v1,
                         output int s0, output int s1);
        int b0 = 0, b1 = 0, d0, d1;
        v0 = 0; v1 = 0; e0 = 0; e1 = 0; s0 = 0; s1 = 0;
        for (int k = 0; k < 4; k++) begin
            int t = (m_ptr + k) % 4;
            if (!icmiss_i[t] && (!v0 || keyof(t) < b0)) begin v0 = 1; e0 = t; b0 = keyof(t); end
        end
        for (int k = 0; k < 4; k++) begin
            int t = (m_ptr + k) % 4;
            if (dual_i && !icmiss_i[t] && !(v0 && t == e0) && (!v1 || keyof(t) < b1)) begin
                v1 = 1; e1 = t; b1 = keyof(t);
            end
        end
        d0 = (dem[e0] > 8) ? 8 : dem[e0];
        d1 = (dem[e1] > 8) ? 8 : dem[e1];
        if (v0) begin
            if (!dual_i) s0 = d0;
            else if (halves_i) begin
                if (v1) begin s0 = (d0 > 4) ? 4 : d0; s1 = (d1 > 4) ? 4 : d1; end
                else s0 = d0;
            end else begin
                s0 = d0;
                if (v1) s1 = (d1 > 8 - d0) ? 8 - d0 : d1;
            end
        end
    endtask

    task automatic check(string tag);
        int e0, e1, s0, s1; bit v0, v1;
        #1;
        model(e0, v0, e1, v1, s0, s1);
        n_chk++;
        if (win0_vld_o !== v0 || win1_vld_o !== v1 ||
            (v0 && win0_id_o !== 2'(e0)) || (v1 && win1_id_o !== 2'(e1)) ||
            win0_slots_o !== 4'(s0) || win1_slots_o !== 4'(s1)) begin
            n_bad++;
            $display("FAIL %s: got v0=%0b id0=%0d v1=%0b id1=%0d s0=%0d s1=%0d exp v0=%0b id0=%0d v1=%0b id1=%0d s0=%0d s1=%0d",
                     tag, win0_vld_o, win0_id_o, win1_vld_o, win1_id_o, win0_slots_o, win1_slots_o,
                     v0, e0, v1, e1, s0, s1);
        end
    endtask

    task automatic tick();
        int e0, e1, s0, s1; bit v0, v1;
        @(posedge clk);
        if (!rst) begin
            model(e0, v0, e1, v1, s0, s1);
            if (v0) m_ptr = (e0 + 1) % 4;
            for (int t = 0; t < 4; t++) begin
                m_fe[t] = sat(m_fe[t], fe_enter_i[t], fe_leave_i[t]);
                m_br[t] = sat(m_br[t], br_enter_i[t], br_resolve_i[t]);
                m_dm[t] = sat(m_dm[t], dm_start_i[t], dm_end_i[t]);
            end
        end
        @(negedge clk);
    endtask

    task automatic step(string tag);
        check(tag);
        tick();
    endtask

    task automatic clear_ev();
        fe_enter_i = '0; fe_leave_i = '0; br_enter_i = '0;
        br_resolve_i = '0; dm_start_i = '0; dm_end_i = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8 reset state");
        if (!(win0_vld_o === 1'b1 && win0_id_o === 2'd0)) begin
            n_chk++; n_bad++;
            $display("FAIL R2 first winner after reset: got %0d exp 0", win0_id_o);
        end else n_chk++;
        tick();
    endtask

    task automatic t_rotate();
        policy_i = 2'd0; dual_i = 0;
        repeat (6) step("R2 rotation");
        dual_i = 1; halves_i = 0;
        repeat (4) step("R2 rotation dual");
        dual_i = 0;
    endtask

    task automatic t_icmiss();
        icmiss_i = 4'b0101;
        repeat (4) step("R1 icache miss excluded");
        policy_i = 2'd3; dual_i = 1;
        repeat (3) step("R1 excluded in count mode");
        icmiss_i = 4'b1110;
        dual_i = 1; halves_i = 1;
        dem = '{7, 8, 8, 8};
        step("R10 lone thread takes full budget");
        dem = '{12, 8, 8, 8};
        step("R10 lone thread demand above 8 limited");
        icmiss_i = '0; dual_i = 0; halves_i = 0; policy_i = 2'd0;
        dem = '{8, 8, 8, 8};
    endtask

    task automatic t_count(int pol, string tag);
        policy_i = 2'(pol);
        for (int t = 0; t < 4; t++) begin
            for (int r = 0; r < 4 - t; r++) begin
                case (pol)
                    1: br_enter_i[t] = 1'b1;
                    2: dm_start_i[t] = 1'b1;
                    default: fe_enter_i[t] = 1'b1;
                endcase
                step(tag);
                clear_ev();
            end
        end
        repeat (2) step(tag);
        for (int r = 0; r < 3; r++) begin
            case (pol)
                1: br_resolve_i = 4'b0001;
                2: dm_end_i = 4'b0001;
                default: fe_leave_i = 4'b0001;
            endcase
            step(tag);
            clear_ev();
        end
        dual_i = 1;
        repeat (2) step(tag);
        dual_i = 0;
    endtask

    task automatic t_tie();
        policy_i = 2'd1;
        br_enter_i = 4'b1111; step("R6 tie setup"); clear_ev();
        repeat (6) step("R6 tie follows pointer");
        br_enter_i = 4'b0100; br_resolve_i = 4'b0100;
        step("R7 same-cycle inc and dec"); clear_ev();
        repeat (3) step("R7 same-cycle inc and dec no change");
    endtask

    task automatic t_sat();
        policy_i = 2'd3;
        for (int t = 0; t < 4; t++) m_fe[t] = m_fe[t];
        fe_leave_i = 4'b1111;
        repeat (12) step("R7 drain to zero");
        clear_ev();
        fe_enter_i = 4'b0001;
        repeat (130) step("R7 upper saturation");
        clear_ev();
        fe_enter_i = 4'b1110; step("R7 rivals at one"); clear_ev();
        fe_leave_i = 4'b0001;
        repeat (127) step("R7 decrement from ceiling");
        clear_ev();
        repeat (2) step("R7 saturated counter returns to zero");
        fe_leave_i = 4'b0010;
        repeat (3) step("R7 lower saturation");
        clear_ev();
        fe_enter_i = 4'b0010; step("R7 lower saturation"); clear_ev();
        repeat (3) step("R7 count after floor");
    endtask

    task automatic t_budget();
        policy_i = 2'd0;
        dual_i = 0;
        dem = '{3, 12, 5, 0};
        repeat (4) step("R8 single winner demand");
        dual_i = 1; halves_i = 0;
        dem = '{3, 6, 8, 2};
        repeat (4) step("R9 second fills leftovers");
        dem = '{15, 4, 1, 9};
        repeat (4) step("R9 first winner takes all");
        halves_i = 1;
        dem = '{8, 2, 6, 15};
        repeat (4) step("R10 halves");
        halves_i = 0; dual_i = 0;
        dem = '{8, 8, 8, 8};
    endtask

    task automatic t_none();
        policy_i = 2'd0; dual_i = 1;
        icmiss_i = 4'b1111;
        repeat (3) step("R12 no eligible thread");
        icmiss_i = '0;
        repeat (3) step("R12 pointer held across stall");
        dual_i = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int t = 0; t < 4; t++) begin m_fe[t] = 0; m_br[t] = 0; m_dm[t] = 0; end
        @(negedge clk);
        t_reset();
        t_rotate();
        t_icmiss();
        t_count(3, "R3 front-end count ranking");
        t_count(1, "R4 branch count ranking");
        t_count(2, "R5 data miss count ranking");
        t_tie();
        t_sat();
        t_budget();
        t_none();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule